// File: doc/BRIEF.md
# Byte-Serial Cut-Through Packet Switch

This block moves fixed-length packets from N input ports to N output ports, one byte per clock on each 8-bit port. A packet always has 256 bytes. Its leading byte carries the sender's identifier and its second byte carries the destination identifier. A strobe beside each input marks the first byte. Each input lane writes every packet byte into its own buffer. When the second byte arrives, the lane derives the target output from the destination identifier and asks for that output straight away. The route is therefore fixed while the header is still coming in.

When the target output is idle and no other lane asks for it, the first byte leaves the output on the same output-clock edge that samples the second input byte. The whole packet then streams out in order, with an output strobe on its first byte. Several lanes can ask for one output in the same cycle. A round-robin choice settles this, and each losing packet waits in its lane buffer until the output has sent its 256th byte. Writes are clocked by the input clock and reads by the output clock. The two clocks are separate nets but must be edge-aligned, as two branches of one clock tree are. This lets the lane hand a packet over with no synchroniser delay.

Top module: `swx_switch`

## Requirements
- R1: While either reset is low and on the first cycle after release, every `sop_out` bit is 0 and every `data_out` byte is 0x00.
- R2: A packet leaves on the output whose index equals its byte 1 (destination identifier) modulo N. With N = 4, this is the two low bits of byte 1.
- R3: If the target output is idle and uncontested, `sop_out` for that output is high on the output edge that samples the packet's byte 1 on the input.
- R4: All 256 bytes of a packet appear on the chosen output in their input order on consecutive output cycles. `sop_out` is high only with byte 0.
- R5: If several lanes ask for one free output in the same cycle, a round-robin choice picks one. The search starts at the lane after the last lane that won that output, and starts at lane 0 after reset. Each loser's byte 0 appears exactly 256 output cycles after the winner's byte 0.
- R6: Bytes on an input while no packet is in progress there (no start strobe since the last packet's 256th byte) are ignored and produce no output.
- R7: An output carries at most one packet at a time. Two `sop_out` pulses on one output are at least 256 cycles apart, and a lane is granted to at most one output at once.
- R8: An output with no packet in progress drives 0x00 with `sop_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input-side clock; input bytes are sampled on its rising edge |
| rst_in_n | input | 1 | Active-low reset of the input-side logic |
| clk_out | input | 1 | Output-side clock, edge-aligned with clk_in |
| rst_out_n | input | 1 | Active-low reset of the output-side logic |
| sop_in | input | N | Per-input start strobe, high with byte 0 only |
| data_in | input | N x 8 | Packed per-input data bytes |
| sop_out | output | N | Per-output start strobe, high with byte 0 only |
| data_out | output | N x 8 | Packed per-output data bytes |

## Verification
The embedded properties check on every cycle the properties that need no packet context. These are: a single winner per arbitration, grants only to requesting lanes, no lane granted to two outputs, and the 256-cycle spacing of output start pulses. Byte order, destination decoding, exact cut-through latency, round-robin order under contention and the silence of stray input bytes need knowledge of what was sent. Only the bench scenarios show those, by following each packet from its input strobe to its last output byte.

// File: rtl/swx_pkg.sv
package swx_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/swx_lane.sv
module swx_lane
  import swx_pkg::*;
#(
  parameter int PKT_LEN = 256,
  parameter int DEPTH   = 512,
  parameter int PW      = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(PKT_LEN)
) (
  input  logic          clk_in,
  input  logic          rst_in_n,
  input  logic          clk_out,
  input  logic          rst_out_n,
  input  logic          sop_in,
  input  byte_t         din,
  input  logic          grant,
  output logic          req_v,
  output logic [PW-1:0] req_port,
  output byte_t         rd_data
);

  // write side (input clock)
  byte_t           mem [DEPTH];
  logic [AW-1:0]   wr_ptr_q, wr_ptr_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [AW-1:0]   start_q, start_d;
  logic [AW-1:0]   pstart_q, pstart_d;
  logic [PW-1:0]   pport_q, pport_d;
  logic            set_q, set_d;
  logic            we, hdr_now;

  assign we      = sop_in || (cnt_q != '0);
  assign hdr_now = !sop_in && (cnt_q == CW'(1));

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    start_d  = start_q;
    pstart_d = pstart_q;
    pport_d  = pport_q;
    set_d    = set_q;
    if (we) wr_ptr_d = wr_ptr_q + AW'(1);
    if (sop_in) begin
      cnt_d   = CW'(1);
      start_d = wr_ptr_q;
    end else if (cnt_q != '0) begin
      cnt_d = (cnt_q == CW'(PKT_LEN - 1)) ? '0 : cnt_q + CW'(1);
    end
    if (hdr_now) begin
      pstart_d = start_q;
      pport_d  = din[PW-1:0];
      set_d    = !set_q;
    end
  end

  always_ff @(posedge clk_in or negedge rst_in_n) begin
    if (!rst_in_n) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      start_q  <= '0;
      pstart_q <= '0;
      pport_q  <= '0;
      set_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
      start_q  <= start_d;
      pstart_q <= pstart_d;
      pport_q  <= pport_d;
      set_q    <= set_d;
    end
  end

  always_ff @(posedge clk_in) begin
    if (we) mem[wr_ptr_q] <= din;
  end

  // read side (output clock)
  logic            clr_q, clr_d;
  logic            strm_q, strm_d;
  logic [CW-1:0]   lrem_q, lrem_d;
  logic [AW-1:0]   rd_ptr_q, rd_ptr_d;
  logic            pend_v;
  logic [AW-1:0]   req_start, rd_addr;

  assign pend_v    = set_q ^ clr_q;
  assign req_v     = (pend_v || hdr_now) && !strm_q;
  assign req_port  = pend_v ? pport_q : din[PW-1:0];
  assign req_start = pend_v ? pstart_q : start_q;
  assign rd_addr   = strm_q ? rd_ptr_q : req_start;
  assign rd_data   = mem[rd_addr];

  always_comb begin
    clr_d    = clr_q;
    strm_d   = strm_q;
    lrem_d   = lrem_q;
    rd_ptr_d = rd_ptr_q;
    if (grant) begin
      clr_d    = !clr_q;
      strm_d   = 1'b1;
      lrem_d   = CW'(PKT_LEN - 1);
      rd_ptr_d = req_start + AW'(1);
    end else if (strm_q) begin
      rd_ptr_d = rd_ptr_q + AW'(1);
      lrem_d   = lrem_q - CW'(1);
      if (lrem_q == CW'(1)) strm_d = 1'b0;
    end
  end

  always_ff @(posedge clk_out or negedge rst_out_n) begin
    if (!rst_out_n) begin
      clr_q    <= 1'b0;
      strm_q   <= 1'b0;
      lrem_q   <= '0;
      rd_ptr_q <= '0;
    end else begin
      clr_q    <= clr_d;
      strm_q   <= strm_d;
      lrem_q   <= lrem_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  p_grant_needs_req_r5: assert property (@(posedge clk_out) disable iff (!rst_out_n)
    grant |-> req_v);

endmodule

// File: rtl/swx_rr_arb.sv
module swx_rr_arb #(
  parameter int N  = 4,
  localparam int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [PW-1:0] win
);

  logic [PW-1:0] rr_q, rr_d;
  logic          found;
  logic [N-1:0]  pick;

  always_comb begin
    int idx;
    pick  = '0;
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N; k++) begin
      idx = int'(rr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found     = 1'b1;
        pick[idx] = 1'b1;
        win       = PW'(idx);
      end
    end
    grant = en ? pick : '0;
    rr_d  = rr_q;
    if (en && found) rr_d = (int'(win) == N - 1) ? '0 : win + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  p_single_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_winner_requested_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

endmodule

// File: rtl/swx_out_port.sv
module swx_out_port
  import swx_pkg::*;
#(
  parameter int N       = 4,
  parameter int PKT_LEN = 256,
  localparam int PW = $clog2(N),
  localparam int CW = $clog2(PKT_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req,
  input  logic [N-1:0][7:0] lane_data,
  output logic [N-1:0]      grant,
  output byte_t             dout,
  output logic              sop
);

  logic          act_q, act_d;
  logic [CW-1:0] rem_q, rem_d;
  logic [PW-1:0] src_q, src_d;
  byte_t         dout_q, dout_d;
  logic          sop_q, sop_d;
  logic          free;
  logic [PW-1:0] win;

  assign free = !act_q || (rem_q == '0);

  swx_rr_arb #(.N(N)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (free),
    .req   (req),
    .grant (grant),
    .win   (win)
  );

  always_comb begin
    act_d  = act_q;
    rem_d  = rem_q;
    src_d  = src_q;
    dout_d = dout_q;
    sop_d  = 1'b0;
    if (free && (grant != '0)) begin
      act_d  = 1'b1;
      rem_d  = CW'(PKT_LEN - 1);
      src_d  = win;
      dout_d = lane_data[win];
      sop_d  = 1'b1;
    end else if (!free) begin
      rem_d  = rem_q - CW'(1);
      dout_d = lane_data[src_q];
    end else begin
      act_d  = 1'b0;
      dout_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rem_q  <= '0;
      src_q  <= '0;
      dout_q <= '0;
      sop_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      rem_q  <= rem_d;
      src_q  <= src_d;
      dout_q <= dout_d;
      sop_q  <= sop_d;
    end
  end

  assign dout = dout_q;
  assign sop  = sop_q;

  // spacing checker: cycles since the last start pulse, saturating
  logic [CW:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gap_q <= (CW+1)'(PKT_LEN);
    else if (sop_q)                  gap_q <= (CW+1)'(1);
    else if (gap_q < (CW+1)'(PKT_LEN)) gap_q <= gap_q + (CW+1)'(1);
  end

  p_sop_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sop_q |-> gap_q == (CW+1)'(PKT_LEN));
  p_sop_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sop_q |=> !sop_q);

endmodule

// File: rtl/swx_switch.sv
module swx_switch
  import swx_pkg::*;
#(
  parameter int N       = 4,
  parameter int PKT_LEN = 256,
  parameter int DEPTH   = 512,
  localparam int PW = $clog2(N)
) (
  input  logic              clk_in,
  input  logic              rst_in_n,
  input  logic              clk_out,
  input  logic              rst_out_n,
  input  logic [N-1:0]      sop_in,
  input  logic [N-1:0][7:0] data_in,
  output logic [N-1:0]      sop_out,
  output logic [N-1:0][7:0] data_out
);

  logic [N-1:0]          req_v;
  logic [PW-1:0]         req_port [N];
  logic [N-1:0][7:0]     lane_data;
  logic [N-1:0]          lane_gnt;
  logic [N-1:0]          req_by_out [N];
  logic [N-1:0]          gnt_by_out [N];
  logic [N-1:0]          gnt_by_lane [N];

  for (genvar i = 0; i < N; i++) begin : g_lane
    swx_lane #(.PKT_LEN(PKT_LEN), .DEPTH(DEPTH), .PW(PW)) u_lane (
      .clk_in    (clk_in),
      .rst_in_n  (rst_in_n),
      .clk_out   (clk_out),
      .rst_out_n (rst_out_n),
      .sop_in    (sop_in[i]),
      .din       (data_in[i]),
      .grant     (lane_gnt[i]),
      .req_v     (req_v[i]),
      .req_port  (req_port[i]),
      .rd_data   (lane_data[i])
    );
  end

  for (genvar o = 0; o < N; o++) begin : g_out
    for (genvar i = 0; i < N; i++) begin : g_req
      assign req_by_out[o][i]  = req_v[i] && (req_port[i] == PW'(o));
      assign gnt_by_lane[i][o] = gnt_by_out[o][i];
    end
    swx_out_port #(.N(N), .PKT_LEN(PKT_LEN)) u_out (
      .clk       (clk_out),
      .rst_n     (rst_out_n),
      .req       (req_by_out[o]),
      .lane_data (lane_data),
      .grant     (gnt_by_out[o]),
      .dout      (data_out[o]),
      .sop       (sop_out[o])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_gnt
    assign lane_gnt[i] = |gnt_by_lane[i];
    p_lane_one_output_r7: assert property (@(posedge clk_out) disable iff (!rst_out_n)
      $onehot0(gnt_by_lane[i]));
  end

endmodule

// File: tb/swx_switch_bench.sv
`timescale 1ns/1ps
module swx_switch_bench;
  localparam int N = 4;
  localparam int L = 256;

  logic              clk;
  logic              rst_n;
  logic [N-1:0]      sop_in;
  logic [N-1:0][7:0] data_in;
  logic [N-1:0]      sop_out;
  logic [N-1:0][7:0] data_out;

  swx_switch #(.N(N), .PKT_LEN(L), .DEPTH(2*L)) u_swx_switch (
    .clk_in    (clk),
    .rst_in_n  (rst_n),
    .clk_out   (clk),
    .rst_out_n (rst_n),
    .sop_in    (sop_in),
    .data_in   (data_in),
    .sop_out   (sop_out),
    .data_out  (data_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  int hdr_cyc [N];
  int start_by_in [N];
  int out_by_in [N];
  int started [N];
  int sentp [N];
  int total_sent = 0, delivered = 0, sops_seen = 0;
  int midsop_err = 0, idle_err = 0;

  function automatic logic [7:0] gen(logic [7:0] s, logic [7:0] d, int k);
    return 8'(s * 29 + d * 7 + k);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int p, input logic [7:0] s, input logic [7:0] d);
    total_sent++;
    sentp[p]++;
    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      sop_in[p]  = (k == 0);
      data_in[p] = (k == 0) ? s : (k == 1) ? d : gen(s, d, k);
      if (k == 1) hdr_cyc[p] = cyc + 1;
    end
    @(negedge clk);
    sop_in[p]  = 1'b0;
    data_in[p] = 8'h00;
  endtask

  // output monitor
  bit        act [N];
  int        idx [N];
  int        perr [N];
  logic [7:0] msrc [N];
  logic [7:0] mdst [N];
  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < N; o++) begin
        if (sop_out[o]) begin
          if (act[o]) midsop_err++;
          act[o]  = 1'b1;
          idx[o]  = 1;
          perr[o] = 0;
          msrc[o] = data_out[o];
          sops_seen++;
          start_by_in[msrc[o] % N] = cyc;
          out_by_in[msrc[o] % N]   = o;
          started[msrc[o] % N]++;
        end else if (act[o]) begin
          if (idx[o] == 1) begin
            mdst[o] = data_out[o];
            if (int'(mdst[o]) % N != o) perr[o]++;
          end else if (data_out[o] != gen(msrc[o], mdst[o], idx[o])) begin
            perr[o]++;
          end
          idx[o]++;
          if (idx[o] == L) begin
            act[o] = 1'b0;
            delivered++;
            chk(perr[o] == 0, "R4 packet bytes", perr[o], 0);
          end
        end else if (data_out[o] != 8'h00) begin
          idle_err++;
        end
      end
    end
  end

  task automatic rand_port(input int p);
    for (int j = 0; j < 6; j++) begin
      wait (started[p] == sentp[p]);
      repeat ($urandom % 20) @(negedge clk);
      send_pkt(p, 8'(((j + 8) << 2) | p), 8'($urandom));
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int s0;
    void'($urandom(32'd5150));
    for (int i = 0; i < N; i++) begin
      started[i] = 0; sentp[i] = 0; hdr_cyc[i] = 0; start_by_in[i] = 0; out_by_in[i] = 0;
    end
    rst_n   = 1'b0;
    sop_in  = '0;
    data_in = '0;
    repeat (4) @(negedge clk);
    chk(sop_out == '0, "R1 sop in reset", int'(sop_out), 0);
    chk(data_out == '0, "R1 data in reset", int'(data_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sop_out == '0 && data_out == '0, "R1 after release", int'(data_out), 0);

    // R3: idle, uncontested cut-through latency
    send_pkt(0, 8'h10, 8'h02);
    repeat (L + 4) @(negedge clk);
    chk(start_by_in[0] == hdr_cyc[0], "R3 latency", start_by_in[0], hdr_cyc[0]);
    chk(out_by_in[0] == 2, "R2 dest 0x02", out_by_in[0], 2);

    // R2: destination above N
    send_pkt(3, 8'h23, 8'h1D);
    repeat (L + 4) @(negedge clk);
    chk(out_by_in[3] == 1, "R2 dest 0x1D", out_by_in[3], 1);
    chk(start_by_in[3] == hdr_cyc[3], "R3 latency port3", start_by_in[3], hdr_cyc[3]);

    // R6: stray bytes with no start strobe
    s0 = sops_seen;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      data_in[1] = 8'($urandom) | 8'h01;
    end
    @(negedge clk);
    data_in[1] = 8'h00;
    repeat (10) @(negedge clk);
    chk(sops_seen == s0, "R6 stray bytes", sops_seen, s0);
    chk(idle_err == 0, "R8 idle data", idle_err, 0);

    // R5: contention, lane 0 wins first after reset
    fork
      send_pkt(0, 8'h14, 8'h03);
      send_pkt(1, 8'h15, 8'h07);
    join
    repeat (2*L + 8) @(negedge clk);
    chk(start_by_in[0] == hdr_cyc[0], "R5 first winner lane0", start_by_in[0], hdr_cyc[0]);
    chk(start_by_in[1] == start_by_in[0] + L, "R5 loser waits", start_by_in[1], start_by_in[0] + L);

    // R5: pointer moved past lane 1, so lane 2 beats lane 0
    fork
      send_pkt(0, 8'h18, 8'h0B);
      send_pkt(2, 8'h1A, 8'h03);
    join
    repeat (2*L + 8) @(negedge clk);
    chk(start_by_in[2] == hdr_cyc[2], "R5 rotated winner lane2", start_by_in[2], hdr_cyc[2]);
    chk(start_by_in[0] == start_by_in[2] + L, "R5 lane0 after lane2", start_by_in[0], start_by_in[2] + L);

    // random traffic
    fork
      rand_port(0);
      rand_port(1);
      rand_port(2);
      rand_port(3);
    join
    wait (delivered == total_sent);
    repeat (8) @(negedge clk);
    chk(delivered == total_sent, "R4 all delivered", delivered, total_sent);
    chk(midsop_err == 0, "R7 no overlap", midsop_err, 0);
    chk(idle_err == 0, "R8 idle data end", idle_err, 0);
    finish_run();
  end
endmodule